// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block decides which interrupt handler a processor runs next. It watches a small set of request lines. Three of them are exception sources with fixed priorities: the reset line at vector 0, the non-maskable line at vector 1 and the hard-fault line at vector 2. The rest are device lines, and software gives each of them a priority through a simple write port. Each line is tracked as inactive, pending, active, or active-and-pending.

On each cycle the controller looks at the pending lines that are not already running and picks the most urgent one. It then decides whether that line may start:

- **Fresh entry:** the processor is in the main thread.
- **Nested entry:** the candidate strictly outranks the running handler.
- **Tail-chained entry:** the candidate is taken in the same cycle a handler returns.

With every entry the block reports the vector index, the kind of entry, and whether the processor must save its context. It keeps a short stack of the priorities of the running handlers, so the current execution priority comes back correctly on each return. Register stacking, vector fetch and instruction flow stay with the processor.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset no line is pending or active, `entry_valid` is 0 and `exec_prio` is 15, the thread level.
- R2: The effective priority is 0, 1 and 2 for vectors 0, 1 and 2. Device line d sits at vector 3+d and has priority (configured value + 3), so it is never equal to or more urgent than a fixed source. A lower number means more urgent.
- R3: When the processor is in the thread and a line is eligible, `entry_valid` pulses on the second rising edge after the request pulse. It carries `entry_kind` 1 (fresh), `stack_req` 1, and `exec_prio` becomes that line's priority.
- R4: Among the eligible pending lines, the one with the lowest effective priority wins. A tie goes to the lowest vector index.
- R5: A pending line whose priority is strictly lower in number than `exec_prio` preempts the running handler. It does so with `entry_kind` 2 (nested) and `stack_req` 1.
- R6: A pending line whose priority is equal to or higher in number than `exec_prio` produces no entry while that handler runs.
- R7: When `ret_strobe` pops a handler and a pending line beats the restored priority, that line is entered on the same edge. It is entered with `entry_kind` 3 (tail chain) and `stack_req` 0.
- R8: Each accepted return restores `exec_prio` to the priority of the handler below it, or to 15 when none remains. A return with nothing active has no effect.
- R9: A request on a line that is already active makes it active-and-pending. The line is not entered again until its own handler returns, and it is then entered by tail chain.
- R10: A request on a line that is already pending is absorbed and yields only one entry.
- R11: At most 4 handlers are nested. A request that would be a fifth level stays pending until a return.
- R12: `cfg_we` writes `cfg_prio` (0 to 7) to device line `cfg_idx`. A write with `cfg_idx` of 4 or more changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 7 | One request pulse per line, vector order |
| cfg_we | input | 1 | Priority write enable |
| cfg_idx | input | 3 | Device line selected for the write |
| cfg_prio | input | 3 | Priority value to write |
| ret_strobe | input | 1 | Running handler has finished |
| entry_valid | output | 1 | One-cycle entry strobe |
| entry_vec | output | 3 | Vector index of the entered line |
| entry_kind | output | 2 | Entry kind: 1 fresh, 2 nested, 3 tail chain |
| stack_req | output | 1 | Processor must save context for this entry |
| exec_prio | output | 4 | Current execution priority (15 = thread) |

## Verification
Different internal faults show up at the ports at different times:

- **Corrupt priority stack:** the fault shows on `exec_prio` in the very cycle after the next return. It also shows up later as a tail chain that should or should not have happened.
- **Stuck active bit:** a re-request on that line never re-enters.
- **Lost pending bit:** an expected tail chain is missing on the next return.
- **Wrong tie-break or priority offset:** the first entry after the offending request reports the wrong `entry_vec`.

A cycle model in the bench compares every output on every cycle, so a wrong state is reported within one return of its cause.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
    localparam int FIXED_CNT = 3;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_FRESH = 2'd1,
        KIND_NEST  = 2'd2,
        KIND_TAIL  = 2'd3
    } entry_kind_e;
endpackage

// File: rtl/irq_best_pick.sv
module irq_best_pick #(
    parameter int NL    = 7,
    parameter int EP_W  = 4,
    parameter int VEC_W = 3
) (
    input  logic [NL-1:0]      elig,
    input  logic [NL*EP_W-1:0] prio_flat,
    output logic               found,
    output logic [VEC_W-1:0]   best_vec,
    output logic [EP_W-1:0]    best_prio
);
    always_comb begin
        found     = 1'b0;
        best_vec  = '0;
        best_prio = '1;
        for (int i = 0; i < NL; i++) begin
            // strict compare keeps the lowest index on ties
            if (elig[i] && (!found || prio_flat[i*EP_W +: EP_W] < best_prio)) begin
                found     = 1'b1;
                best_vec  = VEC_W'(i);
                best_prio = prio_flat[i*EP_W +: EP_W];
            end
        end
    end
endmodule

// File: rtl/irq_active_stack.sv
module irq_active_stack #(
    parameter int DEPTH = 4,
    parameter int VEC_W = 3,
    parameter int EP_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [VEC_W-1:0] push_vec,
    input  logic [EP_W-1:0]  push_prio,
    output logic             empty,
    output logic             full,
    output logic [VEC_W-1:0] top_vec,
    output logic [EP_W-1:0]  top_prio,
    output logic [EP_W-1:0]  under_prio
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][VEC_W-1:0] vec;
        logic [DEPTH-1:0][EP_W-1:0]  prio;
        logic [CNT_W-1:0]            cnt;
    } stk_t;

    stk_t st_d, st_q;
    int   wr_slot;

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CNT_W'(DEPTH));

    always_comb begin
        top_vec    = '0;
        top_prio   = '1;
        under_prio = '1;
        for (int s = 0; s < DEPTH; s++) begin
            if (s == int'(st_q.cnt) - 1) begin
                top_vec  = st_q.vec[s];
                top_prio = st_q.prio[s];
            end
            if (s == int'(st_q.cnt) - 2) under_prio = st_q.prio[s];
        end
    end

    always_comb begin
        st_d    = st_q;
        wr_slot = pop ? int'(st_q.cnt) - 1 : int'(st_q.cnt);
        if (pop && !push) st_d.cnt = st_q.cnt - 1'b1;
        if (push && !pop) st_d.cnt = st_q.cnt + 1'b1;
        if (push) begin
            for (int s = 0; s < DEPTH; s++) begin
                if (s == wr_slot) begin
                    st_d.vec[s]  = push_vec;
                    st_d.prio[s] = push_prio;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_depth_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH)) else $error("stack deeper than limit");
    assert_no_push_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push) |-> pop) else $error("push into full stack");
    assert_no_pop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && empty)) else $error("pop from empty stack");
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int NUM_DEV    = 4,
    parameter int PRIO_W     = 3,
    parameter int NEST_DEPTH = 4,
    localparam int NUM_LINES = FIXED_CNT + NUM_DEV,
    localparam int VEC_W     = $clog2(NUM_LINES),
    localparam int IDX_W     = $clog2(NUM_DEV) + 1,
    localparam int EP_W      = PRIO_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_req,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [PRIO_W-1:0]    cfg_prio,
    input  logic                 ret_strobe,
    output logic                 entry_valid,
    output logic [VEC_W-1:0]     entry_vec,
    output logic [1:0]           entry_kind,
    output logic                 stack_req,
    output logic [EP_W-1:0]      exec_prio
);
    localparam logic [EP_W-1:0] THREAD = '1;

    typedef struct packed {
        logic [NUM_LINES-1:0]           pending;
        logic [NUM_LINES-1:0]           active;
        logic [NUM_DEV-1:0][PRIO_W-1:0] cfg;
        logic                           ent;
        logic [VEC_W-1:0]               vec;
        entry_kind_e                    kind;
        logic                           stk;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_LINES*EP_W-1:0] prio_flat;
    logic [NUM_LINES-1:0]      act_after, elig;
    logic                      found, take, pop;
    logic [VEC_W-1:0]          best_vec, top_vec;
    logic [EP_W-1:0]           best_prio, top_prio, under_prio, thresh;
    logic                      stk_empty, stk_full;

    // effective priorities: fixed sources keep their index, devices are offset past them
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_prio
        if (g < FIXED_CNT) begin : g_fixed
            assign prio_flat[g*EP_W +: EP_W] = EP_W'(g);
        end else begin : g_dev
            assign prio_flat[g*EP_W +: EP_W] =
                {1'b0, ctl_q.cfg[g-FIXED_CNT]} + EP_W'(FIXED_CNT);
        end
    end

    assign pop = ret_strobe && !stk_empty;

    always_comb begin
        act_after = ctl_q.active;
        for (int i = 0; i < NUM_LINES; i++)
            if (pop && top_vec == VEC_W'(i)) act_after[i] = 1'b0;
    end

    assign elig   = ctl_q.pending & ~act_after;
    assign thresh = pop ? under_prio : top_prio;
    assign take   = found && (best_prio < thresh) && (pop || !stk_full);

    irq_best_pick #(.NL(NUM_LINES), .EP_W(EP_W), .VEC_W(VEC_W)) i_pick (
        .elig      (elig),
        .prio_flat (prio_flat),
        .found     (found),
        .best_vec  (best_vec),
        .best_prio (best_prio)
    );

    irq_active_stack #(.DEPTH(NEST_DEPTH), .VEC_W(VEC_W), .EP_W(EP_W)) i_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (take),
        .pop        (pop),
        .push_vec   (best_vec),
        .push_prio  (best_prio),
        .empty      (stk_empty),
        .full       (stk_full),
        .top_vec    (top_vec),
        .top_prio   (top_prio),
        .under_prio (under_prio)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.active  = act_after;
        ctl_d.ent     = take;
        ctl_d.vec     = best_vec;
        ctl_d.stk     = take && !pop;
        ctl_d.kind    = !take ? KIND_NONE : pop ? KIND_TAIL :
                        stk_empty ? KIND_FRESH : KIND_NEST;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (take && best_vec == VEC_W'(i)) begin
                ctl_d.pending[i] = 1'b0;
                ctl_d.active[i]  = 1'b1;
            end
        end
        ctl_d.pending = ctl_d.pending | irq_req;
        for (int d = 0; d < NUM_DEV; d++)
            if (cfg_we && cfg_idx == IDX_W'(d)) ctl_d.cfg[d] = cfg_prio;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            ctl_q.cfg <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign entry_valid = ctl_q.ent;
    assign entry_vec   = ctl_q.vec;
    assign entry_kind  = ctl_q.kind;
    assign stack_req   = ctl_q.stk;
    assign exec_prio   = top_prio;

    assert_tail_no_save_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid && entry_kind == KIND_TAIL) |-> !stack_req)
        else $error("tail chain asked for context save");
    assert_nest_outranks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid && entry_kind == KIND_NEST) |-> exec_prio < $past(exec_prio))
        else $error("nested entry did not raise urgency");
    assert_fresh_from_thread_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid && entry_kind == KIND_FRESH) |-> $past(exec_prio) == THREAD)
        else $error("fresh entry outside thread level");
    assert_entered_is_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
        entry_valid |-> ctl_q.active[entry_vec])
        else $error("entered line not active");
endmodule

// File: tb/test_irq_nest_ctrl.sv
module test_irq_nest_ctrl;
    localparam int NL = 7;
    localparam int ND = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] irq_req = '0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_idx = '0;
    logic [2:0]    cfg_prio = '0;
    logic          ret_strobe = 1'b0;
    logic          entry_valid;
    logic [2:0]    entry_vec;
    logic [1:0]    entry_kind;
    logic          stack_req;
    logic [3:0]    exec_prio;

    int  checks = 0;
    int  fails = 0;
    bit  done = 0;

    // reference model state
    bit [NL-1:0] m_pend, m_act;
    int m_dep;
    int m_svec[4];
    int m_sprio[4];
    int m_cfg[ND];
    bit e_valid, e_stk;
    int e_vec, e_kind, e_exec;

    irq_nest_ctrl i_irq_nest_ctrl (
        .clk, .rst_n, .irq_req, .cfg_we, .cfg_idx, .cfg_prio, .ret_strobe,
        .entry_valid, .entry_vec, .entry_kind, .stack_req, .exec_prio
    );

    always #5 clk = ~clk;

    function automatic int eprio(int i);
        return (i < 3) ? i : m_cfg[i-3] + 3;
    endfunction

    function automatic void model_step(bit [NL-1:0] irq, bit ret, bit we, int idx, int pr);
        bit pop = ret && m_dep > 0;
        bit [NL-1:0] aa = m_act;
        int thr, bp = 99, bv = -1;
        bit take;
        if (pop) begin
            aa[m_svec[m_dep-1]] = 1'b0;
            thr = (m_dep >= 2) ? m_sprio[m_dep-2] : 15;
        end else begin
            thr = (m_dep > 0) ? m_sprio[m_dep-1] : 15;
        end
        for (int i = 0; i < NL; i++)
            if (m_pend[i] && !aa[i] && eprio(i) < bp) begin bp = eprio(i); bv = i; end
        take = (bv >= 0) && bp < thr && (pop || m_dep < 4);
        e_valid = take;
        e_vec = bv;
        e_kind = pop ? 3 : (m_dep == 0 ? 1 : 2);
        e_stk = !pop;
        m_act = aa;
        if (pop) m_dep--;
        if (take) begin
            m_pend[bv] = 1'b0;
            m_act[bv] = 1'b1;
            m_svec[m_dep] = bv;
            m_sprio[m_dep] = bp;
            m_dep++;
        end
        m_pend |= irq;
        if (we && idx < ND) m_cfg[idx] = pr;
        e_exec = (m_dep > 0) ? m_sprio[m_dep-1] : 15;
    endfunction

    task automatic expect_out(bit v, int vec, int kind, bit stk, int ep, string req);
        checks++;
        if (entry_valid !== v || exec_prio !== 4'(ep) ||
            (v && (entry_vec !== 3'(vec) || entry_kind !== 2'(kind) || stack_req !== stk))) begin
            fails++;
            $display("FAIL %s: got v=%0b vec=%0d kind=%0d stk=%0b prio=%0d, expected v=%0b vec=%0d kind=%0d stk=%0b prio=%0d",
                     req, entry_valid, entry_vec, entry_kind, stack_req, exec_prio,
                     v, vec, kind, stk, ep);
        end
    endtask

    // called at a falling edge; leaves at the next falling edge
    task automatic step(bit [NL-1:0] irq = '0, bit ret = 0, bit we = 0, int idx = 0, int pr = 0);
        irq_req = irq; ret_strobe = ret; cfg_we = we;
        cfg_idx = 3'(idx); cfg_prio = 3'(pr);
        @(posedge clk);
        model_step(irq, ret, we, idx, pr);
        @(negedge clk);
        irq_req = '0; ret_strobe = 0; cfg_we = 0;
    endtask

    function automatic bit [NL-1:0] ln(int v);
        return NL'(1) << v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_pend = '0; m_act = '0; m_dep = 0;
        for (int d = 0; d < ND; d++) m_cfg[d] = 7;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out(0, 0, 0, 0, 15, "R1 reset state");

        step('0, 0, 1, 0, 5);
        step('0, 0, 1, 4, 0);           // out-of-range index, R12
        step('0, 0, 1, 1, 2);
        step('0, 0, 1, 2, 5);
        step(ln(3) | ln(5));
        expect_out(0, 0, 0, 0, 15, "R3 no entry before decision");
        step();
        expect_out(1, 3, 1, 1, 8, "R2 R3 R4 R12 fresh tie entry");
        step();
        expect_out(0, 0, 0, 0, 8, "R6 equal priority held");
        step(ln(4));
        expect_out(0, 0, 0, 0, 8, "R5 not yet");
        step();
        expect_out(1, 4, 2, 1, 5, "R5 nested preempt");
        step(ln(4));
        expect_out(0, 0, 0, 0, 5, "R9 active line not re-entered");
        step(ln(4));
        expect_out(0, 0, 0, 0, 5, "R10 repeat absorbed");
        step('0, 1);
        expect_out(1, 4, 3, 0, 5, "R7 R9 tail chain same line");
        step('0, 1);
        expect_out(0, 0, 0, 0, 8, "R8 R10 restore, single re-entry");
        step('0, 1);
        expect_out(1, 5, 3, 0, 8, "R7 tail chain after equal wait");
        step('0, 1);
        expect_out(0, 0, 0, 0, 15, "R8 back to thread");
        step('0, 1);
        expect_out(0, 0, 0, 0, 15, "R8 stray return ignored");

        step(ln(6)); step();
        expect_out(1, 6, 1, 1, 10, "R11 level 1");
        step(ln(3)); step();
        expect_out(1, 3, 2, 1, 8, "R11 level 2");
        step(ln(4)); step();
        expect_out(1, 4, 2, 1, 5, "R11 level 3");
        step(ln(2)); step();
        expect_out(1, 2, 2, 1, 2, "R11 level 4");
        step(ln(1)); step();
        expect_out(0, 0, 0, 0, 2, "R11 fifth level held");
        step('0, 1);
        expect_out(1, 1, 3, 0, 1, "R11 R7 held line chained");
        step('0, 1); expect_out(0, 0, 0, 0, 5, "R8 unwind 1");
        step('0, 1); expect_out(0, 0, 0, 0, 8, "R8 unwind 2");
        step('0, 1); expect_out(0, 0, 0, 0, 10, "R8 unwind 3");
        step('0, 1); expect_out(0, 0, 0, 0, 15, "R8 unwind 4");

        for (int n = 0; n < 4000; n++) begin
            bit [NL-1:0] rq = '0;
            bit rt, w;
            string tag;
            for (int i = 0; i < NL; i++) rq[i] = ($urandom % 14) == 0;
            rt = ($urandom % 3) == 0;
            w  = ($urandom % 20) == 0;
            step(rq, rt, w, int'($urandom % 8), int'($urandom % 8));
            tag = !e_valid ? "R6 R8 idle/held" : e_kind == 1 ? "R3 R4 fresh" :
                  e_kind == 2 ? "R5 R4 nest" : "R7 R4 tail";
            expect_out(e_valid, e_vec, e_kind, e_stk, e_exec, tag);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule